// File: doc/BRIEF.md
# Oversampled Serial Receiver with Noise Detection

This block receives asynchronous serial frames, least significant bit first, from a line that idles high. It advances on a one-cycle enable pulse from an external tick source. A configuration input sets that source to 16 or 8 ticks per bit. A falling edge seen while idle marks the start of a frame. Every later bit is judged from samples taken at the ticks around its centre. A single-sample mode uses only the centre sample.

After the start bit the block takes eight data bits. An optional parity bit, even or odd, follows. The stop interval can be half, one, one and a half or two bits long. At the end of a frame the byte is stored and a full flag is raised. The noise, parity, framing and overrun flags update in the same clock. A read strobe empties the buffer and clears every flag. If a frame ends while the buffer is still full, that frame is dropped and only the overrun flag is raised. A combined interrupt output is formed from the flags and three enable inputs.

Top module: `uart_nrx`

## Requirements
- R1: `cfg_os8`=0 gives 16 ticks per bit and `cfg_os8`=1 gives 8. Frames sent at the selected ratio are received intact in both settings.
- R2: Tick k=0 of a bit is the tick on which the idle-to-low edge is seen, or the first tick after the previous bit. With M = ratio/2, each bit is sampled at ticks k=M-1, M and M+1, and its value is the majority of the three. One flipped sample does not change the value.
- R3: If the three samples of any sampled bit differ, `err_noise` is set for that frame. Sampled bits are the start bit, the data bits, the parity bit and each checked stop bit.
- R4: With `cfg_onesamp`=1 the value of each bit is taken from tick k=M alone, and `err_noise` is never set.
- R5: With `cfg_par_en`=1 a parity bit follows the data. `err_par` is set when the XOR of the data bits and the parity bit differs from `cfg_par_odd` (0 selects even parity, 1 selects odd parity).
- R6: `cfg_stop` selects the stop interval: 00 is one bit, 01 is half a bit, 10 is two bits, 11 is one and a half bits. A checked stop bit that resolves to 0 sets `err_frame`. With 01 the stop interval is not sampled. With 11 the first half-bit is skipped and the following full bit is sampled at its centre.
- R7: With two stop bits, a failing first stop bit sets `err_frame` and ends the frame there, and the second bit is not checked. Otherwise the second stop bit is sampled and checked as well.
- R8: A frame that ends while `rx_full` is 1 is dropped. `rx_data` and the other flags are kept, and `err_ovr` is set.
- R9: `rx_full` and all four error flags update together. This happens one clock after the tick that completes the frame, and they change at no other time except on a read.
- R10: A one-cycle `rd_strobe` clears `rx_full` and all four error flags on the next clock.
- R11: `irq` is high when `ie_err` is 1 and any of noise, frame or overrun is set. It is also high when `ie_par` is 1 and `err_par` is set, or when `ie_full` is 1 and `rx_full` or `err_ovr` is set.
- R12: A start bit whose resolved value is 1 is treated as a false start. The receiver returns to idle with no flag or data change.
- R13: The first data bit received lands in bit 0 of `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick enable, one cycle wide |
| rxd | input | 1 | Serial line, already synchronous to clk |
| cfg_os8 | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| cfg_onesamp | input | 1 | Single centre sample per bit, noise check off |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop | input | 2 | Stop interval length code |
| ie_err | input | 1 | Interrupt enable for noise, frame and overrun |
| ie_par | input | 1 | Interrupt enable for parity error |
| ie_full | input | 1 | Interrupt enable for buffer full and overrun |
| rd_strobe | input | 1 | Read strobe: empties buffer, clears flags |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Buffer holds an unread byte |
| err_noise | output | 1 | Noise seen in the stored frame |
| err_par | output | 1 | Parity mismatch in the stored frame |
| err_frame | output | 1 | Stop bit read as 0 |
| err_ovr | output | 1 | A frame was dropped because the buffer was full |
| irq | output | 1 | Combined interrupt |

## Verification
The stored byte and the flags register on the clock edge that carries the frame's last deciding tick. That tick is k=M+1 of the final checked stop bit, or the last tick of the half-bit interval when the stop interval is half a bit. The results are therefore readable one clock later. The bench drives every tick as a single-cycle pulse followed by an idle cycle, and samples on the falling edge after that pulse. Around the deciding tick of every stored frame it checks that `rx_full` is low just before and high just after. The other outputs are compared after the stop interval and two idle ticks. At that point the registered flags are stable and `irq`, being combinational, follows them in the same cycle.

// File: rtl/uart_nrx_pkg.sv
package uart_nrx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_HALF,
        S_STOP1,
        S_STOP2
    } rx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_HALF     = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_ONE_HALF = 2'b11
    } stop_mode_e;

endpackage

// File: rtl/uart_nrx_vote.sv
module uart_nrx_vote (
    input  logic s_early,
    input  logic s_mid,
    input  logic s_late,
    input  logic one_sample,
    output logic bit_val,
    output logic noisy
);
    logic majority;
    logic agree;

    always_comb begin
        majority = (s_early & s_mid) | (s_early & s_late) | (s_mid & s_late);
        agree    = (s_early == s_mid) && (s_mid == s_late);
        bit_val  = one_sample ? s_mid : majority;
        noisy    = !one_sample && !agree;
    end
endmodule

// File: rtl/uart_nrx_irq.sv
module uart_nrx_irq (
    input  logic ie_err,
    input  logic ie_par,
    input  logic ie_full,
    input  logic full,
    input  logic nerr,
    input  logic perr,
    input  logic ferr,
    input  logic oerr,
    output logic irq
);
    always_comb begin
        irq = (ie_err && (nerr || ferr || oerr))
            || (ie_par && perr)
            || (ie_full && (full || oerr));
    end
endmodule

// File: rtl/uart_nrx.sv
module uart_nrx
    import uart_nrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              cfg_os8,
    input  logic              cfg_onesamp,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic              ie_err,
    input  logic              ie_par,
    input  logic              ie_full,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_noise,
    output logic              err_par,
    output logic              err_frame,
    output logic              err_ovr,
    output logic              irq
);
    localparam int CNT_W = $clog2(OS_HI);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_HI  = CNT_W'(OS_HI / 2);
    localparam logic [CNT_W-1:0] MID_LO  = CNT_W'(OS_LO / 2);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(OS_HI - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(OS_LO - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic              s0;
        logic              s1;
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              par_acc;
        logic              noise_acc;
        logic              prev;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              nerr;
        logic              perr;
        logic              ferr;
        logic              oerr;
    } rx_regs_t;

    localparam rx_regs_t RESET_VAL = '{
        st: S_IDLE, cnt: '0, s0: 1'b1, s1: 1'b1, shreg: '0, idx: '0,
        par_acc: 1'b0, noise_acc: 1'b0, prev: 1'b1, data: '0,
        full: 1'b0, nerr: 1'b0, perr: 1'b0, ferr: 1'b0, oerr: 1'b0
    };

    rx_regs_t   r_q, r_d;
    stop_mode_e smode;
    logic       bit_v, noisy_v;

    assign smode = stop_mode_e'(cfg_stop);

    uart_nrx_vote u_vote (
        .s_early    (r_q.s0),
        .s_mid      (r_q.s1),
        .s_late     (rxd),
        .one_sample (cfg_onesamp),
        .bit_val    (bit_v),
        .noisy      (noisy_v)
    );

    always_comb begin
        logic [CNT_W-1:0] mid, last;
        logic             at_early, at_mid, at_late, at_last, at_half;
        logic             finish, fin_noise, fin_ferr;
        rx_state_e        stop_entry;

        mid        = cfg_os8 ? MID_LO : MID_HI;
        last       = cfg_os8 ? LAST_LO : LAST_HI;
        at_early   = (r_q.cnt == mid - 1'b1);
        at_mid     = (r_q.cnt == mid);
        at_late    = (r_q.cnt == mid + 1'b1);
        at_last    = (r_q.cnt == last);
        at_half    = (r_q.cnt == mid - 1'b1);
        stop_entry = (smode == STOP_ONE || smode == STOP_TWO) ? S_STOP1 : S_HALF;
        finish     = 1'b0;
        fin_noise  = r_q.noise_acc;
        fin_ferr   = 1'b0;

        r_d = r_q;

        if (rd_strobe) begin
            r_d.full = 1'b0;
            r_d.nerr = 1'b0;
            r_d.perr = 1'b0;
            r_d.ferr = 1'b0;
            r_d.oerr = 1'b0;
        end

        if (tick) begin
            r_d.prev = rxd;
            if (r_q.st != S_IDLE) begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (at_early) r_d.s0 = rxd;
                if (at_mid)   r_d.s1 = rxd;
            end
            unique case (r_q.st)
                S_IDLE: begin
                    if (r_q.prev && !rxd) begin
                        r_d.st        = S_START;
                        r_d.cnt       = CNT_W'(1);
                        r_d.noise_acc = 1'b0;
                        r_d.par_acc   = 1'b0;
                        r_d.idx       = '0;
                    end
                end
                S_START: begin
                    if (at_late) begin
                        r_d.noise_acc = r_q.noise_acc | noisy_v;
                        if (bit_v) begin
                            r_d.st  = S_IDLE;
                            r_d.cnt = '0;
                        end
                    end
                    if (at_last) begin
                        r_d.cnt = '0;
                        r_d.st  = S_DATA;
                    end
                end
                S_DATA: begin
                    if (at_late) begin
                        r_d.noise_acc = r_q.noise_acc | noisy_v;
                        r_d.shreg     = {bit_v, r_q.shreg[DATA_W-1:1]};
                        r_d.par_acc   = r_q.par_acc ^ bit_v;
                    end
                    if (at_last) begin
                        r_d.cnt = '0;
                        if (r_q.idx == IDX_END) begin
                            r_d.st = cfg_par_en ? S_PAR : stop_entry;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                S_PAR: begin
                    if (at_late) begin
                        r_d.noise_acc = r_q.noise_acc | noisy_v;
                        r_d.par_acc   = r_q.par_acc ^ bit_v;
                    end
                    if (at_last) begin
                        r_d.cnt = '0;
                        r_d.st  = stop_entry;
                    end
                end
                S_HALF: begin
                    if (at_half) begin
                        r_d.cnt = '0;
                        if (smode == STOP_HALF) finish = 1'b1;
                        else                    r_d.st = S_STOP1;
                    end
                end
                S_STOP1: begin
                    if (at_late) begin
                        r_d.noise_acc = r_q.noise_acc | noisy_v;
                        if (!bit_v || smode != STOP_TWO) begin
                            finish    = 1'b1;
                            fin_noise = r_q.noise_acc | noisy_v;
                            fin_ferr  = !bit_v;
                        end
                    end
                    if (at_last) begin
                        r_d.cnt = '0;
                        r_d.st  = S_STOP2;
                    end
                end
                S_STOP2: begin
                    if (at_late) begin
                        finish    = 1'b1;
                        fin_noise = r_q.noise_acc | noisy_v;
                        fin_ferr  = !bit_v;
                    end
                end
                default: r_d.st = S_IDLE;
            endcase
        end

        if (finish) begin
            r_d.st  = S_IDLE;
            r_d.cnt = '0;
            if (r_d.full) begin
                r_d.oerr = 1'b1;
            end else begin
                r_d.data = r_q.shreg;
                r_d.full = 1'b1;
                r_d.nerr = fin_noise;
                r_d.perr = cfg_par_en && (r_q.par_acc ^ cfg_par_odd);
                r_d.ferr = fin_ferr;
                r_d.oerr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign rx_data   = r_q.data;
    assign rx_full   = r_q.full;
    assign err_noise = r_q.nerr;
    assign err_par   = r_q.perr;
    assign err_frame = r_q.ferr;
    assign err_ovr   = r_q.oerr;

    uart_nrx_irq u_irq (
        .ie_err  (ie_err),
        .ie_par  (ie_par),
        .ie_full (ie_full),
        .full    (r_q.full),
        .nerr    (r_q.nerr),
        .perr    (r_q.perr),
        .ferr    (r_q.ferr),
        .oerr    (r_q.oerr),
        .irq     (irq)
    );
endmodule

// File: rtl/uart_nrx_checker.sv
module uart_nrx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rd_strobe,
    input logic              cfg_onesamp,
    input logic              ie_err,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              err_noise,
    input logic              err_par,
    input logic              err_frame,
    input logic              err_ovr,
    input logic              irq
);
    // R9: stored state moves only on a tick or a read
    p_update_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !rd_strobe) |=> $stable({rx_full, err_noise, err_par, err_frame, err_ovr, rx_data}));

    // R9: error flags never stand without a stored byte
    p_flags_need_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_noise || err_par || err_frame || err_ovr) |-> rx_full);

    // R8: a full buffer keeps its byte until read
    p_keep_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_strobe) |=> $stable(rx_data));

    // R10: a read leaves no overrun behind
    p_read_clears_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !err_ovr);

    // R4: single-sample mode never raises noise
    p_no_noise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_noise) |-> !$past(cfg_onesamp));

    // R11: enabled error flags reach the interrupt
    p_irq_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_err && (err_frame || err_noise || err_ovr)) |-> irq);
endmodule

bind uart_nrx uart_nrx_checker #(.DATA_W(DATA_W)) u_uart_nrx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rd_strobe   (rd_strobe),
    .cfg_onesamp (cfg_onesamp),
    .ie_err      (ie_err),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .err_noise   (err_noise),
    .err_par     (err_par),
    .err_frame   (err_frame),
    .err_ovr     (err_ovr),
    .irq         (irq)
);

// File: tb/uart_nrx_bench.sv
module uart_nrx_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_os8 = 1'b0, cfg_onesamp = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'b00;
    logic       ie_err = 1'b0, ie_par = 1'b0, ie_full = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_noise, err_par, err_frame, err_ovr, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model of the stored state
    logic [7:0] m_data = 8'h00;
    logic m_full = 0, m_n = 0, m_p = 0, m_f = 0, m_o = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_nrx u_uart_nrx (
        .clk, .rst_n, .tick, .rxd, .cfg_os8, .cfg_onesamp, .cfg_par_en,
        .cfg_par_odd, .cfg_stop, .ie_err, .ie_par, .ie_full, .rd_strobe,
        .rx_data, .rx_full, .err_noise, .err_par, .err_frame, .err_ovr, .irq
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic v);
        @(negedge clk);
        rxd  = v;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m_full = 0; m_n = 0; m_p = 0; m_f = 0; m_o = 0;
    endtask

    function automatic int ratio();
        return cfg_os8 ? 8 : 16;
    endfunction

    // which frame positions are sampled: 0 start, 1..8 data, 9 parity, 10 stop1, 11 stop2
    function automatic bit pos_sampled(input int pos, input logic [1:0] bad);
        if (pos < 0) return 0;
        if (pos <= 8) return 1;
        if (pos == 9) return cfg_par_en;
        if (pos == 10) return cfg_stop != 2'b01;
        if (pos == 11) return (cfg_stop == 2'b10) && !bad[0];
        return 0;
    endfunction

    function automatic logic exp_irq();
        return (ie_err && (m_n || m_f || m_o)) || (ie_par && m_p) || (ie_full && (m_full || m_o));
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " R13/R1 rx_data"}, rx_data, m_data);
        chk({tag, " R9 rx_full"}, rx_full, m_full);
        chk({tag, " R3/R4 err_noise"}, err_noise, m_n);
        chk({tag, " R5 err_par"}, err_par, m_p);
        chk({tag, " R6/R7 err_frame"}, err_frame, m_f);
        chk({tag, " R8 err_ovr"}, err_ovr, m_o);
        chk({tag, " R11 irq"}, irq, exp_irq());
    endtask

    task automatic send_frame(input logic [7:0] data, input bit par_flip,
                              input logic [1:0] bad, input int noise_pos);
        int os, mid, nb, stop_len, off1, fin_t;
        bit do_flip, exp_n, exp_f, exp_p, store;
        logic bits [0:9];
        logic fb, fa, v;
        os  = ratio();
        mid = os / 2;
        do_flip = pos_sampled(noise_pos, bad);
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i + 1] = data[i];
        bits[9] = (^data) ^ cfg_par_odd ^ par_flip;
        nb = cfg_par_en ? 10 : 9;
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < os; k++) begin
                v = bits[b];
                if (do_flip && noise_pos == b && k == mid - 1) v = ~v;
                do_tick(v);
            end
        end
        case (cfg_stop)
            2'b00: begin stop_len = os;          off1 = 0;      fin_t = mid + 1; end
            2'b01: begin stop_len = os / 2;      off1 = 0;      fin_t = os / 2 - 1; end
            2'b10: begin stop_len = 2 * os;      off1 = 0;      fin_t = bad[0] ? mid + 1 : os + mid + 1; end
            default: begin stop_len = os + os/2; off1 = os / 2; fin_t = os / 2 + mid + 1; end
        endcase
        store = !m_full;
        fb = 1'b0; fa = 1'b0;
        for (int t = 0; t < stop_len; t++) begin
            v = (cfg_stop == 2'b10 && t >= os) ? !bad[1] : !bad[0];
            if (do_flip && noise_pos == 10 && t == off1 + mid - 1) v = ~v;
            if (do_flip && noise_pos == 11 && t == os + mid - 1) v = ~v;
            if (t == fin_t) fb = rx_full;
            do_tick(v);
            if (t == fin_t) fa = rx_full;
        end
        if (store) begin
            chk("R9 full low before deciding tick", fb, 0);
            chk("R9 full high one clock after deciding tick", fa, 1);
        end
        do_tick(1'b1);
        do_tick(1'b1);
        // expected result
        exp_n = do_flip && !cfg_onesamp;
        exp_p = cfg_par_en && par_flip;
        exp_f = (cfg_stop != 2'b01 && bad[0]) || (cfg_stop == 2'b10 && !bad[0] && bad[1]);
        if (m_full) begin
            m_o = 1;
        end else begin
            m_full = 1; m_data = data; m_n = exp_n; m_p = exp_p; m_f = exp_f; m_o = 0;
        end
    endtask

    task automatic set_cfg(input logic os8, input logic one, input logic pen,
                           input logic podd, input logic [1:0] stp);
        @(negedge clk);
        cfg_os8 = os8; cfg_onesamp = one; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop = stp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("reset");

        // R13/R1 directed: plain frame at 16x, LSB first
        set_cfg(0, 0, 0, 0, 2'b00);
        send_frame(8'h01, 0, 2'b00, -1);
        check_state("R13 lsb first 16x");
        do_read();
        check_state("R10 after read");

        // R1 at 8x with odd parity
        set_cfg(1, 0, 1, 1, 2'b00);
        send_frame(8'hA5, 0, 2'b00, -1);
        check_state("R1 8x odd parity clean");
        do_read();

        // R2/R3 noise on one data sample: data intact, noise set
        set_cfg(0, 0, 0, 0, 2'b00);
        send_frame(8'h3C, 0, 2'b00, 4);
        check_state("R2 R3 noisy data bit");
        do_read();

        // R4 single sample: off-centre flip ignored, no noise
        set_cfg(0, 1, 0, 0, 2'b00);
        send_frame(8'h3C, 0, 2'b00, 4);
        check_state("R4 single sample");
        do_read();

        // R5 even parity error
        set_cfg(0, 0, 1, 0, 2'b00);
        ie_par = 1;
        send_frame(8'h7E, 1, 2'b00, -1);
        check_state("R5 even parity error");
        do_read();
        ie_par = 0;

        // R6 half stop: bad stop not sampled
        set_cfg(1, 0, 0, 0, 2'b01);
        send_frame(8'h55, 0, 2'b01, -1);
        check_state("R6 half stop unsampled");
        do_read();

        // R6 one and a half stop: bad stop detected, noise on stop
        set_cfg(0, 0, 0, 0, 2'b11);
        send_frame(8'h81, 0, 2'b00, 10);
        check_state("R6 1.5 stop noise");
        do_read();
        send_frame(8'h81, 0, 2'b01, -1);
        check_state("R6 1.5 stop frame error");
        do_read();

        // R7 two stops: first bad, second bad only
        set_cfg(0, 0, 0, 0, 2'b10);
        ie_err = 1;
        send_frame(8'h12, 0, 2'b01, -1);
        check_state("R7 first stop bad");
        do_read();
        send_frame(8'h34, 0, 2'b10, 11);
        check_state("R7 second stop bad with noise");
        do_read();
        ie_err = 0;

        // R8 overrun with full-enable interrupt only
        set_cfg(1, 0, 0, 0, 2'b00);
        ie_full = 1;
        send_frame(8'hC3, 0, 2'b00, -1);
        send_frame(8'h99, 0, 2'b01, 3);
        check_state("R8 overrun keeps old frame");
        do_read();
        check_state("R10 clear after overrun");
        ie_full = 0;

        // R12 false start: short low glitch
        set_cfg(0, 0, 0, 0, 2'b00);
        do_tick(1'b0);
        do_tick(1'b0);
        for (int i = 0; i < 24; i++) do_tick(1'b1);
        check_state("R12 false start ignored");
        send_frame(8'hE7, 0, 2'b00, -1);
        check_state("R12 next frame after glitch");
        do_read();

        // random mix
        for (int n = 0; n < 48; n++) begin
            int np;
            set_cfg($urandom % 2, ($urandom % 4) == 0, $urandom % 2, $urandom % 2, 2'($urandom % 4));
            ie_err  = $urandom % 2;
            ie_par  = $urandom % 2;
            ie_full = $urandom % 2;
            np = ($urandom % 2) ? int'($urandom % 12) : -1;
            send_frame(8'($urandom), ($urandom % 3) == 0, 2'(($urandom % 4) == 0 ? $urandom % 4 : 0), np);
            check_state("random frame");
            if (($urandom % 4) != 0) do_read();
        end

        finish_run();
    end
endmodule